// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog for a system that has to recover by itself when its software stops responding. A down-counter runs from a timeout that software picks as a power of two. Software restarts the count before it runs out by writing a fixed key word. If the count does run out, the block does one of two things, chosen by a response-mode bit. It can request a system reset at once. Or it can first raise an interrupt, which gives software one more full period to acknowledge before the reset request goes out.

The register port is a simple 32-bit strobe interface: one write strobe, one read strobe, a byte address, write data and combinational read data. Once software sets the enable bit, software cannot clear it again; only the hardware reset can. A read of the acknowledge register clears a pending interrupt and also restarts the count, so software that answers every interrupt keeps the watchdog from ever resetting the system. The reset request is a pulse of fixed length. After it, the block freezes until the external reset returns every register to its reset value.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the irq and rst_req outputs are 0, every register reads 0, and the count register reads 2^BASE_SHIFT - 1.
- R2: Control bit 0 (offset 0x00) is the enable bit. A write of 1 sets it. Writes of 0 do not clear it; only rst_n does. Control bit 1 is the response-mode bit, and software can write it freely.
- R3: The count register (offset 0x08) is read-only and returns the live count. The count does not change while the enable bit is 0.
- R4: The timeout field is bits 3:0 at offset 0x04. With field value t the period is 2^(BASE_SHIFT+t) cycles. The counter expires on the period-th enabled clock edge after a restart.
- R5: A write of the key 0x76 to offset 0x0C loads the counter with the period minus one. The period comes from the timeout field as it stands, so a timeout write followed by the key takes effect at once.
- R6: A write to offset 0x0C of any value other than 0x76 leaves the counter and the interrupt state unchanged.
- R7: With response mode 0, the first expiry raises rst_req and never sets irq.
- R8: With response mode 1, the first expiry sets irq, and bit 0 of the status register (offset 0x10) reads 1. The counter reloads and keeps running.
- R9: With response mode 1, an expiry while irq is already pending raises rst_req.
- R10: A read of offset 0x14 clears irq and reloads the counter with the current period.
- R11: A restart by key write or by acknowledge read, on the same edge as an expiry, takes priority: no expiry takes place.
- R12: rst_req stays high for exactly RST_LEN cycles. After that the counter stays frozen and rst_req stays low until rst_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect on the acknowledge register) |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from addr |
| irq | output | 1 | Watchdog interrupt, high while pending |
| rst_req | output | 1 | System reset request pulse |

## Verification
Two events can fall on the same clock edge. One is the counter reaching zero, which would raise the interrupt or the reset. The other is software restarting the count, either with a key write or with an acknowledge read. The bench counts edges from a known restart so that the restart strobe lands exactly on the edge where the count sits at zero: once with an acknowledge read while an interrupt is pending, and once with a key write. It judges the result at the ports. No reset pulse appears, the interrupt ends cleared (or stays clear), and the count register reads the full reloaded period minus one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // register offsets (software decodes these)
   localparam int OFS_CTRL = 'h00;
   localparam int OFS_TOR  = 'h04;
   localparam int OFS_CNT  = 'h08;
   localparam int OFS_KICK = 'h0C;
   localparam int OFS_STAT = 'h10;
   localparam int OFS_ACK  = 'h14;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_MODE_BIT = 1;

   localparam int KICK_KEY = 'h76;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_PULSE = 2'd1,
      ST_HALT  = 2'd2
   } resp_state_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int TOR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              irq_i,
   output logic              en_o,
   output logic              mode_o,
   output logic [TOR_W-1:0]  tor_o,
   output logic              kick_o,
   output logic              ack_o,
   output logic [DATA_W-1:0] rdata_o
);

   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("count width exceeds data width");
   end
   if (TOR_W > DATA_W) begin : g_chk_tor
      $error("timeout field exceeds data width");
   end

   logic hit_ctrl, hit_tor, hit_cnt, hit_kick, hit_stat, hit_ack;
   logic en_q, mode_q;
   logic [TOR_W-1:0] tor_q;

   assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
   assign hit_tor  = (addr_i == ADDR_W'(OFS_TOR));
   assign hit_cnt  = (addr_i == ADDR_W'(OFS_CNT));
   assign hit_kick = (addr_i == ADDR_W'(OFS_KICK));
   assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));
   assign hit_ack  = (addr_i == ADDR_W'(OFS_ACK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= 1'b0;
         tor_q  <= '0;
      end else if (wr_en_i) begin
         if (hit_ctrl) begin
            en_q   <= en_q | wdata_i[CTRL_EN_BIT];
            mode_q <= wdata_i[CTRL_MODE_BIT];
         end
         if (hit_tor) begin
            tor_q <= wdata_i[TOR_W-1:0];
         end
      end
   end

   assign kick_o = wr_en_i && hit_kick && (wdata_i == DATA_W'(KICK_KEY));
   assign ack_o  = rd_en_i && hit_ack;
   assign en_o   = en_q;
   assign mode_o = mode_q;
   assign tor_o  = tor_q;

   always_comb begin
      rdata_o = '0;
      if (hit_ctrl) begin
         rdata_o[CTRL_EN_BIT]   = en_q;
         rdata_o[CTRL_MODE_BIT] = mode_q;
      end else if (hit_tor) begin
         rdata_o[TOR_W-1:0] = tor_q;
      end else if (hit_cnt) begin
         rdata_o = DATA_W'(count_i);
      end else if (hit_stat) begin
         rdata_o[0] = irq_i;
      end
   end

   assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W      = 32,
   parameter int TOR_W      = 4,
   parameter int BASE_SHIFT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TOR_W-1:0] tor_i,
   input  logic             run_i,
   input  logic             reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   localparam int MAX_SHIFT = BASE_SHIFT + (1 << TOR_W) - 1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] RST_VAL = (ONE << BASE_SHIFT) - ONE;

   if (MAX_SHIFT >= CNT_W) begin : g_chk_width
      $error("counter too narrow for the largest period");
   end

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] period_m1;

   assign period_m1 = (ONE << (CNT_W'(BASE_SHIFT) + CNT_W'(tor_i))) - ONE;
   assign expire_o  = run_i && !reload_i && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= RST_VAL;
      end else if (reload_i) begin
         count_q <= period_m1;
      end else if (run_i) begin
         if (count_q == '0) count_q <= period_m1;
         else               count_q <= count_q - ONE;
      end
   end

   assign count_o = count_q;

   assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !reload_i) |=> $stable(count_q));

   assert_reload_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i |=> (count_q == $past(period_m1)));

   assert_expire_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> (count_q != '0));

endmodule

// File: rtl/wdog_resp.sv
module wdog_resp
   import wdog_pkg::*;
#(
   parameter int RST_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic mode_i,
   input  logic ack_i,
   output logic irq_o,
   output logic rst_req_o,
   output logic halt_o
);

   if (RST_LEN < 1) begin : g_chk_len
      $error("reset pulse length must be at least one cycle");
   end

   resp_state_e state_q;
   logic        irq_q;
   logic        pulse_done;

   if (RST_LEN == 1) begin : g_single
      assign pulse_done = 1'b1;
   end else begin : g_multi
      localparam int PW = $clog2(RST_LEN);
      logic [PW-1:0] pcnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  pcnt_q <= '0;
         else if (state_q == ST_PULSE) pcnt_q <= pcnt_q + PW'(1);
         else                         pcnt_q <= '0;
      end
      assign pulse_done = (pcnt_q == PW'(RST_LEN - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         irq_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_RUN: begin
               if (ack_i) begin
                  irq_q <= 1'b0;
               end else if (expire_i) begin
                  if (mode_i && !irq_q) irq_q   <= 1'b1;
                  else                  state_q <= ST_PULSE;
               end
            end
            ST_PULSE: begin
               if (pulse_done) state_q <= ST_HALT;
            end
            default: state_q <= ST_HALT;
         endcase
      end
   end

   assign irq_o     = irq_q;
   assign rst_req_o = (state_q == ST_PULSE);
   assign halt_o    = (state_q != ST_RUN);

   assert_direct_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && !mode_i && !halt_o) |=> (rst_req_o && !irq_o));

   assert_first_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && mode_i && !irq_o && !halt_o) |=> (irq_o && !rst_req_o));

   assert_second_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && irq_o && !halt_o) |=> rst_req_o);

   assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !halt_o) |=> !irq_o);

   assert_halt_final_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_o && !rst_req_o) |=> (halt_o && !rst_req_o));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int TOR_W      = 4,
   parameter int BASE_SHIFT = 16,
   parameter int RST_LEN    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              rst_req
);

   localparam int CNT_W = BASE_SHIFT + (1 << TOR_W);

   if (ADDR_W < 5) begin : g_chk_addr
      $error("address too narrow for the register map");
   end
   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("BASE_SHIFT too large for the data width");
   end

   logic             en, mode, kick, ack, halt, expire;
   logic [TOR_W-1:0] tor;
   logic [CNT_W-1:0] count;

   wdog_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TOR_W(TOR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
      .count_i(count), .irq_i(irq),
      .en_o(en), .mode_o(mode), .tor_o(tor), .kick_o(kick), .ack_o(ack),
      .rdata_o(rdata)
   );

   wdog_counter #(
      .CNT_W(CNT_W), .TOR_W(TOR_W), .BASE_SHIFT(BASE_SHIFT)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .tor_i(tor), .run_i(en && !halt), .reload_i((kick || ack) && !halt),
      .count_o(count), .expire_o(expire)
   );

   wdog_resp #(
      .RST_LEN(RST_LEN)
   ) u_resp (
      .clk(clk), .rst_n(rst_n),
      .expire_i(expire), .mode_i(mode), .ack_i(ack),
      .irq_o(irq), .rst_req_o(rst_req), .halt_o(halt)
   );

   assert_foreign_word_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_KICK) && wdata != DATA_W'(KICK_KEY) && !en)
      |=> ($stable(count) && $stable(irq)));

   assert_restart_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((kick || ack) && en && !halt && count == '0) |=> !rst_req);

endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int BASE   = 4;
   localparam int RLEN   = 8;

   localparam logic [7:0] A_CTRL = 8'h00, A_TOR = 8'h04, A_CNT = 8'h08,
                          A_KICK = 8'h0C, A_STAT = 8'h10, A_ACK = 8'h14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0, rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              irq, rst_req;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;   // 10 time-unit period, nominal 100 MHz

   wdog_timer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOR_W(4), .BASE_SHIFT(BASE), .RST_LEN(RLEN)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset;
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset_state;
      logic [31:0] v;
      do_reset();
      check("R1 irq", irq, 0);
      check("R1 rst_req", rst_req, 0);
      rd(A_CTRL, v); check("R1 ctrl", v, 0);
      rd(A_TOR, v);  check("R1 tor", v, 0);
      rd(A_STAT, v); check("R1 stat", v, 0);
      rd(A_CNT, v);  check("R1 cnt", v, 15);
      tick(10);
      rd(A_CNT, v);  check("R3 disabled hold", v, 15);
   endtask

   task automatic t_sticky;
      logic [31:0] v;
      do_reset();
      wr(A_CTRL, 3);
      wr(A_CTRL, 0);
      rd(A_CTRL, v); check("R2 enable sticky, mode cleared", v, 1);
      wr(A_CTRL, 2);
      rd(A_CTRL, v); check("R2 mode set", v, 3);
   endtask

   task automatic t_kick_and_ignore;
      logic [31:0] v;
      do_reset();
      wr(A_TOR, 15);
      wr(A_KICK, 32'h76);
      rd(A_CNT, v); check("R5 largest period", v, (32'd1 << 19) - 1);
      wr(A_TOR, 2);
      wr(A_KICK, 32'h76);
      rd(A_CNT, v); check("R5 new period at once", v, 63);
      wr(A_KICK, 32'h75);
      rd(A_CNT, v); check("R6 foreign word, disabled", v, 63);
      wr(A_CTRL, 3);
      tick(10);                              // count 53
      wr(A_KICK, 32'h176);                   // count 52
      rd(A_CNT, v); check("R6 foreign word, running / R3 live", v, 52);
      check("R6 irq untouched", irq, 0);
   endtask

   task automatic t_mode1;
      logic [31:0] v;
      int n;
      do_reset();
      wr(A_TOR, 1);                          // period 32
      wr(A_KICK, 32'h76);
      wr(A_CTRL, 3);
      tick(31);
      check("R4 no expiry one cycle early", irq, 0);
      tick(1);
      check("R8 irq on first expiry", irq, 1);
      check("R8 no reset on first expiry", rst_req, 0);
      rd(A_STAT, v); check("R8 status bit", v, 1);  // count 30
      tick(5);                                      // count 25
      rd(A_ACK, v);                                 // reload 31
      check("R10 ack clears irq", irq, 0);
      rd(A_CNT, v); check("R10 ack restarts count", v, 31);  // count 30 after
      tick(31);
      check("R8 irq again", irq, 1);
      tick(31);
      check("R9 no reset before second expiry", rst_req, 0);
      tick(1);
      check("R9 reset on second expiry", rst_req, 1);
      n = 0;
      while (rst_req === 1'b1 && n < 100) begin
         n++;
         tick(1);
      end
      check("R12 pulse length", n, RLEN);
      rd(A_CNT, v);
      tick(40);
      begin
         logic [31:0] w;
         rd(A_CNT, w); check("R12 frozen after pulse", w, v);
      end
      check("R12 no second pulse", rst_req, 0);
   endtask

   task automatic t_mode0;
      int n;
      do_reset();
      wr(A_KICK, 32'h76);                    // count 15
      wr(A_CTRL, 1);
      tick(15);
      check("R7 not yet", rst_req, 0);
      tick(1);
      check("R7 reset on first expiry", rst_req, 1);
      check("R7 irq never set", irq, 0);
      n = 0;
      while (rst_req === 1'b1 && n < 100) begin
         n++;
         check("R7 irq stays clear", irq, 0);
         tick(1);
      end
      check("R12 pulse length mode 0", n, RLEN);
   endtask

   task automatic t_collision;
      logic [31:0] v;
      do_reset();
      wr(A_KICK, 32'h76);                    // count 15
      wr(A_CTRL, 3);
      tick(16);
      check("R11 setup irq", irq, 1);        // count 15
      tick(15);                              // count 0
      rd(A_ACK, v);                          // ack on expiry edge
      check("R11 ack wins, irq cleared", irq, 0);
      check("R11 ack wins, no reset", rst_req, 0);
      rd(A_CNT, v); check("R11 ack wins, reloaded", v, 15);  // count 14 after
      tick(14);                              // count 0
      wr(A_KICK, 32'h76);                    // key on expiry edge
      check("R11 key wins, no irq", irq, 0);
      check("R11 key wins, no reset", rst_req, 0);
      rd(A_CNT, v); check("R11 key wins, reloaded", v, 15);
   endtask

   initial begin
      t_reset_state();
      t_sticky();
      t_kick_and_ignore();
      t_mode1();
      t_mode0();
      t_collision();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule